// File: doc/BRIEF.md
# Rotated-Load Alignment Unit

This unit sits between a processor's load/store request port and a data memory that is one 32-bit word wide. For every request it looks at the access kind, the byte address and two configuration bits. It then decides whether the access faults, whether its result is undefined, and what address the memory sees. In legacy mode, word accesses are rounded down to the enclosing word. For a word load, the returned word is byte-rotated so that the addressed byte lands in the least significant lane.

In modern mode, an unaligned word or halfword access is not changed. It goes out with its full byte address and a split marker, so that a downstream splitter can break it into smaller accesses. The data that comes back is passed through as it is. An alignment-check bit overrides both modes: any access not aligned to its natural size is refused before it reaches memory.

The unit handles one request at a time. Every accepted request produces exactly one single-cycle response pulse, which carries the data and the fault and undefined-result flags.

Top module: `rotload_align`

## Requirements
- R1: In legacy mode (`cfg_legacy`=1), a word store (kind 1), a multiple load (kind 4) or a multiple store (kind 5) is issued with address bits [1:0] cleared. No data rotation is applied, so an aligned multiple load returns the memory word unchanged. `mem_write` is 1 for kinds 1 and 5, and a store response carries zero data.
- R2: In legacy mode, a word load (kind 0) reads the word at the address with bits [1:0] cleared. It returns that word rotated right by 8 times the original address bits [1:0].
- R3: A halfword load (kind 2) in legacy mode with address bit 1 set raises `rsp_unpred`. The read still goes to the rounded word address, and the returned data is unspecified.
- R4: A halfword load that is not split returns the 16-bit lane picked by address bit 1 (bit 1 = 0 picks bits [15:0]), zero-extended to 32 bits. In legacy mode an odd address with bit 1 clear selects the low lane.
- R5: A doubleword access (kind 3) whose address is not a multiple of 4 raises `rsp_unpred` in either mode. It is issued at the rounded word address, and an aligned one returns the memory word unchanged.
- R6: When `cfg_chk_en`=1, an access not aligned to its natural size faults. The natural size is 2 bytes for kind 2 and 4 bytes for all other kinds. A faulting access never drives `mem_valid`, responds with `rsp_fault`=1 and zero data, and takes priority over the legacy round-and-rotate path.
- R7: In modern mode (`cfg_legacy`=0) with checking off, an unaligned word load or store, or a halfword load with bit 0 set, is issued with its unmodified byte address and `mem_split`=1. The load data is returned without rotation, taking only the low 16 bits for a halfword.
- R8: A multiple transfer (kind 4 or 5) whose address is not a multiple of 4 raises `rsp_unpred` in both modes. It is never split.
- R9: A faulting access or a store responds in the cycle after it is accepted. A load responds in the cycle after `mem_rvalid` is seen, however long the memory takes.
- R10: While a load is outstanding, `req_ready` and `mem_valid` stay low. With `mem_ready` low, a non-faulting request is not accepted. A `mem_rvalid` with no load outstanding produces no response.
- R11: After reset, `rsp_valid` and `mem_valid` are 0, and with `mem_ready` high and no fault the unit is ready.
- R12: The reserved kind codes 6 and 7 always fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chk_en | input | 1 | Alignment check enable |
| cfg_legacy | input | 1 | 1 = round-and-rotate behaviour, 0 = forward for splitting |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_kind | input | 3 | Access kind: 0 word load, 1 word store, 2 halfword load, 3 doubleword, 4 multiple load, 5 multiple store, 6/7 reserved |
| req_addr | input | ADDR_W | Byte address |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_addr | output | ADDR_W | Address sent to memory (rounded, or raw when split) |
| mem_write | output | 1 | Access is a store |
| mem_split | output | 1 | Access must be split downstream |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Formatted load data |
| rsp_fault | output | 1 | Alignment fault or reserved kind |
| rsp_unpred | output | 1 | Result is undefined |

## Verification
The memory-side outputs are combinational from the request, so the bench checks them shortly after driving a request and before the accepting edge. A fault or store response is due at the edge that accepts the request, and is checked at the falling edge just after it. A load response is due at the edge that samples `mem_rvalid`, so the bench supplies read data one cycle after acceptance and checks the response at the following falling edge. The bench also confirms that `rsp_valid` is still low before that edge. Directed cases add a memory stall, a slow read with the response held back for several cycles, and a stray read-valid while idle, each sampled at the exact cycle it is due.

// File: rtl/rla_pkg.sv
package rla_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFS_W  = $clog2(LANES);
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        K_LDW  = 3'd0,
        K_STW  = 3'd1,
        K_LDH  = 3'd2,
        K_DBL  = 3'd3,
        K_LDM  = 3'd4,
        K_STM  = 3'd5,
        K_RSV6 = 3'd6,
        K_RSV7 = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        SH_ROT  = 2'd0,
        SH_HALF = 2'd1,
        SH_RAW  = 2'd2,
        SH_NONE = 2'd3
    } shape_e;

    typedef struct packed {
        logic             fault;
        logic             unpred;
        logic             split;
        logic             write;
        logic             is_load;
        shape_e           shape;
        logic [OFS_W-1:0] ofs;
    } cls_t;

    typedef struct packed {
        logic              busy;
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_data;
        logic              rsp_fault;
        logic              rsp_unpred;
        logic              pend_unpred;
        shape_e            shape;
        logic [OFS_W-1:0]  ofs;
    } state_t;
endpackage

// File: rtl/rla_decode.sv
module rla_decode
    import rla_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chk_en,
    input  logic              legacy,
    output cls_t              cls,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [OFS_W-1:0] ofs;
    logic             word_mis;
    logic             half_mis;
    logic             mis;

    always_comb begin
        ofs      = addr[OFS_W-1:0];
        word_mis = (ofs != '0);
        half_mis = ofs[0];
        mis      = 1'b0;
        cls      = '0;
        cls.shape = SH_NONE;
        cls.ofs   = ofs;
        case (kind)
            K_LDW: begin
                mis         = word_mis;
                cls.is_load = 1'b1;
                cls.split   = !legacy && word_mis;
                cls.shape   = cls.split ? SH_RAW : SH_ROT;
            end
            K_STW: begin
                mis       = word_mis;
                cls.write = 1'b1;
                cls.split = !legacy && word_mis;
            end
            K_LDH: begin
                mis         = half_mis;
                cls.is_load = 1'b1;
                cls.split   = !legacy && half_mis;
                cls.unpred  = legacy && ofs[OFS_W-1];
                cls.shape   = SH_HALF;
                if (cls.split) cls.ofs = '0;
            end
            K_DBL, K_LDM: begin
                mis         = word_mis;
                cls.is_load = 1'b1;
                cls.unpred  = word_mis;
                cls.shape   = SH_RAW;
            end
            K_STM: begin
                mis        = word_mis;
                cls.write  = 1'b1;
                cls.unpred = word_mis;
            end
            default: cls.fault = 1'b1;
        endcase
        if (chk_en && mis) cls.fault = 1'b1;
        if (cls.fault) begin
            cls.unpred  = 1'b0;
            cls.split   = 1'b0;
            cls.write   = 1'b0;
            cls.is_load = 1'b0;
            cls.shape   = SH_NONE;
        end
        mem_addr = cls.split ? addr : {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        // R1 / R7: only a split access may leave the word grid
        if (!cls.split) begin
            assert_word_grid_R1 : assert (mem_addr[OFS_W-1:0] == '0);
        end
    end
endmodule

// File: rtl/rla_format.sv
module rla_format
    import rla_pkg::*;
(
    input  shape_e            shape,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] data
);
    logic [WORD_W-1:0] rot;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        localparam logic [OFS_W-1:0] BI = OFS_W'(b);
        logic [OFS_W-1:0] src;
        assign src = BI + ofs;
        assign rot[8*b +: 8] = rdata[{src, 3'b000} +: 8];
    end

    always_comb begin
        case (shape)
            SH_ROT:  data = rot;
            SH_HALF: data = {{HALF_W{1'b0}},
                             ofs[OFS_W-1] ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0]};
            SH_RAW:  data = rdata;
            default: data = '0;
        endcase
        // R4: a halfword result never carries upper bits
        if (shape == SH_HALF) begin
            assert_half_zext_R4 : assert (data[WORD_W-1:HALF_W] == '0);
        end
    end
endmodule

// File: rtl/rotload_align.sv
module rotload_align
    import rla_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_chk_en,
    input  logic              cfg_legacy,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic              mem_split,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_fault,
    output logic              rsp_unpred
);
    cls_t              cls;
    state_t            state_d, state_q;
    logic [WORD_W-1:0] fmt_data;
    logic              accept;

    rla_decode #(.ADDR_W(ADDR_W)) u_decode (
        .kind     (kind_e'(req_kind)),
        .addr     (req_addr),
        .chk_en   (cfg_chk_en),
        .legacy   (cfg_legacy),
        .cls      (cls),
        .mem_addr (mem_addr)
    );

    rla_format u_format (
        .shape (state_q.shape),
        .ofs   (state_q.ofs),
        .rdata (mem_rdata),
        .data  (fmt_data)
    );

    assign req_ready  = !state_q.busy && (cls.fault || mem_ready);
    assign mem_valid  = req_valid && !state_q.busy && !cls.fault;
    assign mem_write  = cls.write;
    assign mem_split  = cls.split;
    assign accept     = req_valid && req_ready;
    assign rsp_valid  = state_q.rsp_valid;
    assign rsp_data   = state_q.rsp_data;
    assign rsp_fault  = state_q.rsp_fault;
    assign rsp_unpred = state_q.rsp_unpred;

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        if (state_q.busy && mem_rvalid) begin
            state_d.busy       = 1'b0;
            state_d.rsp_valid  = 1'b1;
            state_d.rsp_data   = fmt_data;
            state_d.rsp_fault  = 1'b0;
            state_d.rsp_unpred = state_q.pend_unpred;
        end else if (accept) begin
            if (cls.fault || !cls.is_load) begin
                state_d.rsp_valid  = 1'b1;
                state_d.rsp_data   = '0;
                state_d.rsp_fault  = cls.fault;
                state_d.rsp_unpred = cls.unpred;
            end else begin
                state_d.busy        = 1'b1;
                state_d.shape       = cls.shape;
                state_d.ofs         = cls.ofs;
                state_d.pend_unpred = cls.unpred;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R6: a fault response follows an accepted request that never reached memory
    assert_fault_no_mem_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> $past(req_valid && req_ready && !mem_valid));

    // R9: read data while waiting yields the response on the next cycle
    assert_load_latency_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && mem_rvalid) |=> (rsp_valid && !state_q.busy));

    // R10: waiting only starts after a memory read handshake
    assert_wait_after_read_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.busy) |-> $past(mem_valid && mem_ready && !mem_write));
endmodule

// File: tb/rotload_align_test.sv
`timescale 1ns/1ps
module rotload_align_test;
    localparam logic [31:0] BASE  = 32'h1000_0000;
    localparam logic [31:0] RDATA = 32'h4433_2211;

    typedef struct packed {
        logic [3:0]  tag;
        logic [2:0]  kind;
        logic [1:0]  off;
        logic        leg;
        logic        chk;
        logic        flt;
        logic        unp;
        logic        spl;
        logic        wr;
        logic        ld;
        logic        cd;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 23;
    //  tag kind off leg chk | flt unp spl wr ld cd | data
    localparam vec_t VEC [NV] = '{
        '{4'd2,  3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h4433_2211}, // R2
        '{4'd2,  3'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1144_3322}, // R2
        '{4'd2,  3'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h2211_4433}, // R2
        '{4'd2,  3'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h3322_1144}, // R2
        '{4'd7,  3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4433_2211}, // R7
        '{4'd6,  3'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R6
        '{4'd1,  3'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0},         // R1
        '{4'd7,  3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0},         // R7
        '{4'd4,  3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_2211}, // R4
        '{4'd3,  3'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R3
        '{4'd4,  3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_4433}, // R4
        '{4'd7,  3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_2211}, // R7
        '{4'd6,  3'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R6
        '{4'd3,  3'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R3
        '{4'd5,  3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h4433_2211}, // R5
        '{4'd5,  3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R5
        '{4'd8,  3'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},         // R8
        '{4'd8,  3'd5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},         // R8
        '{4'd6,  3'd5, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R6
        '{4'd12, 3'd6, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R12
        '{4'd6,  3'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},         // R6
        '{4'd4,  3'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_2211}, // R4
        '{4'd1,  3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h4433_2211}  // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_chk_en = 1'b0, cfg_legacy = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [31:0] req_addr = 32'h0;
    logic        mem_valid, mem_ready = 1'b1, mem_write, mem_split;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        rsp_valid, rsp_fault, rsp_unpred;
    logic [31:0] rsp_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rotload_align #(.ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_chk_en(cfg_chk_en), .cfg_legacy(cfg_legacy),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_split(mem_split), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_fault(rsp_fault), .rsp_unpred(rsp_unpred)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        vec_t  v;
        string t;
        v = VEC[i];
        t = $sformatf("R%0d[v%0d]", v.tag, i);
        @(negedge clk);
        cfg_legacy = v.leg; cfg_chk_en = v.chk;
        req_kind = v.kind; req_addr = BASE | 32'(v.off); req_valid = 1'b1;
        #1;
        check(t, "req_ready", 32'(req_ready), 32'd1);
        check(t, "mem_valid", 32'(mem_valid), 32'(!v.flt));
        if (!v.flt) begin
            check(t, "mem_addr", mem_addr, v.spl ? (BASE | 32'(v.off)) : BASE);
            check(t, "mem_write", 32'(mem_write), 32'(v.wr));
            check(t, "mem_split", 32'(mem_split), 32'(v.spl));
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (v.ld && !v.flt) begin
            mem_rdata = RDATA; mem_rvalid = 1'b1;
            #1;
            check(t, "rsp early", 32'(rsp_valid), 32'd0);
            @(posedge clk);
            @(negedge clk);
            mem_rvalid = 1'b0;
        end
        #1;
        check(t, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(t, "rsp_fault", 32'(rsp_fault), 32'(v.flt));
        check(t, "rsp_unpred", 32'(rsp_unpred), 32'(v.unp));
        if (v.cd) check(t, "rsp_data", rsp_data, v.data);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R11", "mem_valid in reset", 32'(mem_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "req_ready after reset", 32'(req_ready), 32'd1);
        check("R11", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: memory stall holds off acceptance, then a slow read (R9)
        @(negedge clk);
        cfg_legacy = 1'b1; cfg_chk_en = 1'b0; mem_ready = 1'b0;
        req_kind = 3'd0; req_addr = BASE | 32'd1; req_valid = 1'b1;
        #1;
        check("R10", "ready while stalled", 32'(req_ready), 32'd0);
        check("R10", "mem_valid while stalled", 32'(mem_valid), 32'd1);
        @(posedge clk);
        @(negedge clk);
        check("R10", "no rsp while stalled", 32'(rsp_valid), 32'd0);
        mem_ready = 1'b1;
        #1;
        check("R10", "ready after stall", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_kind = 3'd1; req_addr = BASE;
        #1;
        check("R10", "ready while waiting", 32'(req_ready), 32'd0);
        check("R10", "mem_valid while waiting", 32'(mem_valid), 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9", "rsp before read data", 32'(rsp_valid), 32'd0);
        end
        req_valid = 1'b0;
        mem_rdata = 32'hA1B2_C3D4; mem_rvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        check("R9", "slow load rsp_valid", 32'(rsp_valid), 32'd1);
        check("R2", "slow load rotated", rsp_data, 32'hD4A1_B2C3);
        @(posedge clk);
        @(negedge clk);
        check("R9", "rsp is one pulse", 32'(rsp_valid), 32'd0);

        // R10: stray read data while idle is ignored
        mem_rvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        check("R10", "stray rvalid ignored", 32'(rsp_valid), 32'd0);
        check("R10", "ready after stray", 32'(req_ready), 32'd1);

        // R12: reserved code 7 faults even with checking off in modern mode
        @(negedge clk);
        cfg_legacy = 1'b0; req_kind = 3'd7; req_addr = BASE; req_valid = 1'b1;
        #1;
        check("R12", "kind 7 no mem access", 32'(mem_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R12", "kind 7 fault", 32'(rsp_fault), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule